// File: doc/BRIEF.md
# Edge-Capturing Interrupt Input Port

This block is a memory-mapped input port for pushbuttons, sensor strobes and other slow external signals. Each input line first passes through a synchronizer. An edge detector then watches the synchronized line. When the chosen kind of edge appears, the matching bit of a sticky capture register is set. A per-line enable register selects which captured bits may take part in the single interrupt request. That request is the OR of the captured bits that are enabled, and no line has priority over another.

Software sees the port through a small synchronous register bus. One offset returns the current synchronized input levels. One offset holds the interrupt enables. One offset holds the captured edges.

How a write clears the capture register is fixed when the block is built:

- In whole-register mode, any write to the capture offset clears every bit, including a write of zero.
- In per-bit mode, each 1 in the write data clears the matching bit, and each 0 leaves its bit as it is. Writing zeros in this mode therefore leaves a pending interrupt asserted.

When several lines capture edges in the same cycle, every one of their bits is kept, so software can service them one at a time.

Top module: `gpio_edge_irq`

## Requirements
- R1: A synchronous active-high reset clears the capture register, the enable register and the edge history. `irq_out` is low after reset. A level held on the inputs throughout reset is not captured as an edge after reset.
- R2: Offset 0 reads the input levels after a two-flop synchronizer. A new level is readable two clock edges after it appears on `pins_in`. Writes to offset 0 change nothing.
- R3: With `EDGE_SEL` = EDGE_RISE (0), a 0-to-1 change on input n sets bit n of the capture register (offset 3) on the third clock edge after the change. A 1-to-0 change captures nothing.
- R4: With `EDGE_SEL` = EDGE_BOTH (2), both rising and falling changes are captured. With EDGE_FALL (1), only 1-to-0 changes are captured.
- R5: A captured bit stays set, whatever later happens on its input, until a write clears it.
- R6: Offset 2 is the read/write enable register, with bit n enabling line n. `irq_out` is high exactly when some captured bit has its enable bit set. A captured bit that is not enabled is still held and readable.
- R7: With `PER_BIT_CLEAR` = 1, a write to offset 3 clears only the bits written as 1. Writing zero clears nothing, and `irq_out` stays high.
- R8: With `PER_BIT_CLEAR` = 0, any write to offset 3, including zero, clears every captured bit.
- R9: Edges arriving on several lines in the same cycle are all captured and held together.
- R10: When an edge on line n and a write that clears bit n take effect on the same clock edge, bit n ends set.
- R11: Offset 1 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register offset for read and write |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational from registers |
| pins_in | input | WIDTH | Asynchronous input lines |
| irq_out | output | 1 | Interrupt request |

## Verification
A level change on `pins_in` can be read at offset 0 after two rising edges. The matching capture bit, and `irq_out` with it, follows on the third edge. A register write takes effect on the edge that samples the strobe, and the read data reflects it right after that edge.

The bench drives inputs on falling edges and compares results half a period later. A pin change is checked after a wait of four edges, and a write is checked on the falling edge after the write. The coincidence test times its clear write onto the third edge after the pin change, which is exactly the edge where the capture lands.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;

    // Which transition of a synchronized input counts as an event.
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_sel_e;

    // Register offsets; software depends on these.
    localparam int OFF_LEVEL = 0;
    localparam int OFF_MASK  = 2;
    localparam int OFF_CAP   = 3;

    // Decoded write strobes from the bus decoder.
    typedef struct packed {
        logic mask_we;
        logic cap_we;
    } wr_strobe_t;

    // Event test for one line: current and previous synchronized value.
    function automatic logic line_event(logic cur, logic old, edge_sel_e sel);
        logic ev;
        case (sel)
            EDGE_RISE: ev = cur & ~old;
            EDGE_FALL: ev = ~cur & old;
            default:   ev = cur ^ old;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_cap_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter int        STAGES   = 2,
    parameter edge_sel_e EDGE_SEL = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] hits
);
    // History is valid once the synchronizer and the old-value register are filled.
    localparam int ARM_CNT = STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CNT + 1);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] old_q;
    logic [CNT_W-1:0] arm_cnt_q;
    logic             armed;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= pins;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign level = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q     <= '0;
            arm_cnt_q <= '0;
        end else begin
            old_q <= level;
            if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
        end
    end

    assign armed = (arm_cnt_q == CNT_W'(ARM_CNT));

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            hits[i] = armed & line_event(level[i], old_q[i], EDGE_SEL);
        end
    end

    // R1: no event reaches the capture logic before the history is filled
    p_quiet_until_armed_r1: assert property (@(posedge clk) disable iff (rst)
        (arm_cnt_q != CNT_W'(ARM_CNT)) |-> (hits == '0));

    // R3: an event always reflects a change of the synchronized level
    p_event_is_change_r3: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |-> ((hits & (level ^ old_q)) == hits));

endmodule

// File: rtl/gpio_cap_reg.sv
module gpio_cap_reg
    import gpio_cap_pkg::*;
#(
    parameter int WIDTH         = 4,
    parameter bit PER_BIT_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    input  logic [WIDTH-1:0] hits,
    output logic [WIDTH-1:0] cap
);
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] clr_vec;
    logic [WIDTH-1:0] cap_d;

    generate
        if (PER_BIT_CLEAR) begin : g_w1c
            assign clr_vec = clr_we ? clr_data : '0;
        end else begin : g_wall
            assign clr_vec = clr_we ? '1 : '0;
        end
    endgenerate

    // New events are ORed in after the clear, so a coincident event survives.
    assign cap_d = (cap_q & ~clr_vec) | hits;

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign cap = cap_q;

    // R5: without a clear write no captured bit drops
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    // R9: every event of a cycle is held on the next edge
    p_all_events_held_r9: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |=> ((cap_q & $past(hits)) == $past(hits)));

    // R10: an event beats a clear write on the same edge
    p_event_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_we && (hits != '0)) |=> ((cap_q & $past(hits)) == $past(hits)));

    // R3: a bit only becomes set through an event
    p_set_needs_event_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_q & ~$past(cap_q) & ~$past(hits)) == '0);

    generate
        if (PER_BIT_CLEAR) begin : g_chk_w1c
            // R7: writing zeros leaves every captured bit in place
            p_zero_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
                (clr_we && (clr_data == '0)) |=> (cap_q == ($past(cap_q) | $past(hits))));
        end else begin : g_chk_wall
            // R8: any write leaves only the events of that cycle
            p_write_clears_all_r8: assert property (@(posedge clk) disable iff (rst)
                clr_we |=> (cap_q == $past(hits)));
        end
    endgenerate

endmodule

// File: rtl/gpio_reg_if.sv
module gpio_reg_if
    import gpio_cap_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  level,
    input  logic [WIDTH-1:0]  cap,
    output wr_strobe_t        strobe,
    output logic [WIDTH-1:0]  mask,
    output logic [WIDTH-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(OFF_CAP);

    logic [WIDTH-1:0] mask_q;

    always_comb begin
        strobe.mask_we = wr && (addr == A_MASK);
        strobe.cap_we  = wr && (addr == A_CAP);
    end

    always_ff @(posedge clk) begin
        if (rst)                 mask_q <= '0;
        else if (strobe.mask_we) mask_q <= wdata;
    end

    assign mask = mask_q;

    always_comb begin
        case (addr)
            A_LEVEL: rdata = level;
            A_MASK:  rdata = mask_q;
            A_CAP:   rdata = cap;
            default: rdata = '0;
        endcase
    end

    // R6: enable register keeps its value unless written at its own offset
    p_mask_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr && (addr == A_MASK)) |=> $stable(mask_q));

    // R11: the unmapped offsets read zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (addr != A_LEVEL && addr != A_MASK && addr != A_CAP) |-> (rdata == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_cap_pkg::*;
#(
    parameter int        WIDTH         = 4,
    parameter int        ADDR_W        = 2,
    parameter int        SYNC_STAGES   = 2,
    parameter edge_sel_e EDGE_SEL      = EDGE_RISE,
    parameter bit        PER_BIT_CLEAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pins_in,
    output logic              irq_out
);
    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] hits;
    logic [WIDTH-1:0] cap;
    logic [WIDTH-1:0] mask;
    wr_strobe_t       strobe;

    gpio_in_sync #(
        .WIDTH    (WIDTH),
        .STAGES   (SYNC_STAGES),
        .EDGE_SEL (EDGE_SEL)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pins  (pins_in),
        .level (level),
        .hits  (hits)
    );

    gpio_cap_reg #(
        .WIDTH         (WIDTH),
        .PER_BIT_CLEAR (PER_BIT_CLEAR)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (strobe.cap_we),
        .clr_data (bus_wdata),
        .hits     (hits),
        .cap      (cap)
    );

    gpio_reg_if #(
        .WIDTH  (WIDTH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .level  (level),
        .cap    (cap),
        .strobe (strobe),
        .mask   (mask),
        .rdata  (bus_rdata)
    );

    // One request line for the whole port, no priority among lines.
    assign irq_out = |(cap & mask);

    // R6: a raised request always has a captured and enabled line behind it
    p_irq_has_source_r6: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (cap != '0 && mask != '0));

    // R1: the request is low on the first edge after reset
    p_irq_low_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !irq_out);

endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
    import gpio_cap_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          wr_a = 1'b0;
    logic          wr_b = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  pins = '0;
    logic [W-1:0]  rdata_a, rdata_b;
    logic          irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Rising edges, per-bit clear
    gpio_edge_irq #(.WIDTH(W), .ADDR_W(AW), .EDGE_SEL(EDGE_RISE), .PER_BIT_CLEAR(1'b1)) i_gpio_edge_irq (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(wr_a), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_a), .pins_in(pins), .irq_out(irq_a));

    // Both edges, whole-register clear
    gpio_edge_irq #(.WIDTH(W), .ADDR_W(AW), .EDGE_SEL(EDGE_BOTH), .PER_BIT_CLEAR(1'b0)) i_gpio_edge_irq_b (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(wr_b), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_b), .pins_in(pins), .irq_out(irq_b));

    typedef struct packed {
        logic          is_pins;  // 1: drive pins and wait; 0: write unit A
        logic [AW-1:0] addr;
        logic [W-1:0]  data;
        logic [AW-1:0] chk;
        logic [W-1:0]  exp;
        logic          exp_irq;
        logic [3:0]    req;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t TABLE [NROWS] = '{
        '{1'b0, 2'd2, 4'b0011, 2'd2, 4'b0011, 1'b0, 4'd6},  // R6 enable write
        '{1'b1, 2'd0, 4'b0001, 2'd3, 4'b0001, 1'b1, 4'd3},  // R3 rise captured
        '{1'b1, 2'd0, 4'b0000, 2'd3, 4'b0001, 1'b1, 4'd5},  // R5 fall keeps bit
        '{1'b1, 2'd0, 4'b0000, 2'd0, 4'b0000, 1'b1, 4'd2},  // R2 level read
        '{1'b1, 2'd0, 4'b0110, 2'd3, 4'b0111, 1'b1, 4'd9},  // R9 two lines at once
        '{1'b0, 2'd3, 4'b0000, 2'd3, 4'b0111, 1'b1, 4'd7},  // R7 zero write keeps
        '{1'b0, 2'd3, 4'b0001, 2'd3, 4'b0110, 1'b1, 4'd7},  // R7 clear bit 0 only
        '{1'b0, 2'd3, 4'b0010, 2'd3, 4'b0100, 1'b0, 4'd6},  // R6 unenabled bit held
        '{1'b0, 2'd2, 4'b0100, 2'd2, 4'b0100, 1'b1, 4'd6},  // R6 enable bit 2
        '{1'b0, 2'd0, 4'b1111, 2'd0, 4'b0110, 1'b1, 4'd2},  // R2 level write ignored
        '{1'b0, 2'd1, 4'b1111, 2'd1, 4'b0000, 1'b1, 4'd11}, // R11 unmapped reads zero
        '{1'b0, 2'd3, 4'b0100, 2'd3, 4'b0000, 1'b0, 4'd7},  // R7 clear last bit
        '{1'b1, 2'd0, 4'b1110, 2'd3, 4'b1000, 1'b0, 4'd6},  // R6 capture while disabled
        '{1'b0, 2'd2, 4'b0000, 2'd2, 4'b0000, 1'b0, 4'd6}   // R6 enables off
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive_pins(input logic [W-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_bus(input bit to_b, input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        if (to_b) wr_b = 1'b1; else wr_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        bus_addr = a;
        #1;
    endtask

    function automatic logic [W-1:0] bit4(input logic b);
        return {3'b000, b};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        look(2'd3); check("R1 cap A", rdata_a, 4'b0000); check("R1 cap B", rdata_b, 4'b0000);
        look(2'd2); check("R1 mask A", rdata_a, 4'b0000);
        check("R1 irq A", bit4(irq_a), 4'b0000);

        // Table walk on unit A
        for (int i = 0; i < NROWS; i++) begin
            if (TABLE[i].is_pins) drive_pins(TABLE[i].data);
            else write_bus(1'b0, TABLE[i].addr, TABLE[i].data);
            look(TABLE[i].chk);
            check($sformatf("R%0d row %0d data", TABLE[i].req, i), rdata_a, TABLE[i].exp);
            check($sformatf("R%0d row %0d irq", TABLE[i].req, i), bit4(irq_a), bit4(TABLE[i].exp_irq));
        end

        // R4 unit B saw every change in both directions
        look(2'd3); check("R4 cap B all edges", rdata_b, 4'b1111);
        check("R6 irq B without enables", bit4(irq_b), 4'b0000);
        // R8 a zero write clears everything
        write_bus(1'b1, 2'd3, 4'b0000);
        look(2'd3); check("R8 zero write clears B", rdata_b, 4'b0000);
        write_bus(1'b1, 2'd2, 4'b0101);

        // Bit 2 falls: B captures it, A (rise only) does not
        drive_pins(4'b1010);
        look(2'd3); check("R4 fall captured by B", rdata_b, 4'b0100);
        check("R3 fall ignored by A", rdata_a, 4'b1000);
        check("R6 irq B raised", bit4(irq_b), 4'b0001);
        drive_pins(4'b1011);
        look(2'd3); check("R3 rise A", rdata_a, 4'b1001); check("R4 rise B", rdata_b, 4'b0101);
        // R8 writing a single bit clears all of B
        write_bus(1'b1, 2'd3, 4'b0001);
        look(2'd3); check("R8 clear all B", rdata_b, 4'b0000);
        check("R8 irq B dropped", bit4(irq_b), 4'b0000);

        // R10 clear of bit 0 lands on the same edge as a new rise of line 0
        drive_pins(4'b1010);
        look(2'd3); check("R5 A holds through fall", rdata_a, 4'b1001);
        @(negedge clk);
        pins = 4'b1011;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 4'b0001; wr_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_a = 1'b0;
        look(2'd3); check("R10 event beats clear", rdata_a, 4'b1001);

        // R1 levels held through reset are not captured
        @(negedge clk);
        pins = 4'b1111;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        look(2'd3); check("R1 no capture A", rdata_a, 4'b0000); check("R1 no capture B", rdata_b, 4'b0000);
        look(2'd0); check("R2 level after reset", rdata_a, 4'b1111);
        check("R1 irq after reset", bit4(irq_a | irq_b), 4'b0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule